// File: doc/BRIEF.md
# Triggered DMA Channel Sequencer

This block is one channel of a DMA engine. Once it has been given a configuration, it copies a programmed number of elements from a source region to a destination region. It uses a single-request memory port, and each element is one read followed by one write. Each region has its own base address and its own signed step. The step is counted in elements, so one step of the pointer equals the increment shifted by the element size. A software start pulse or a hardware trigger pulse releases a portion of the work. How large that portion is depends on the completion action and on the trigger granularity that were loaded with the configuration.

Status is reported in four ways. `busy` covers the whole time that a released portion is in flight, including stalls. A sticky event vector feeds a masked interrupt line. An output pulse marks completed elements, bursts or whole transfers. `enabled` shows whether the channel will accept triggers. A configuration is checked when it is loaded and is refused if it is malformed. Misaligned start addresses and error responses from the memory end a transfer cleanly, and each records a cause bit.

Top module: `dma_chan_seq`

## Requirements
- R1: A `cfgLoad` pulse while idle takes the configuration only if all of the following hold: `cfgWidthBits` is 8, 16 or 32; `cfgLength` is nonzero; and `cfgBurst` is 0 or divides `cfgLength` exactly. An accepted load sets `enabled` and clears `cfgReject`. Any other load sets `cfgReject` and leaves the stored configuration and `enabled` unchanged.
- R2: Element k reads `src + k*srcInc*B` and writes the read value to `dst + k*dstInc*B`, where B is the element size in bytes and the increments are signed. `memSize` is 0, 1 or 2 for 1, 2 or 4 bytes. An element takes one read cycle and one write cycle when the memory acknowledges at once.
- R3: With `cfgBurst` = 0, a software start moves the entire length, whatever the completion action.
- R4: `cfgAction` has four codes. Code 0 is one burst per start. Code 1 is the rest of the length per start. Code 2 is one burst per start, then disable at the end. Code 3 is the rest of the length per start, then disable at the end. After the last element the addresses and counts restart from the base values.
- R5: Event bit 0 (transfer complete) is set after each burst under codes 0 and 2 when `cfgBurst` is nonzero; otherwise it is set once, at the end of the length. Event bit 1 (descriptor complete) is set only when the whole length has moved.
- R6: `cfgInGran` sets how much one `hwTrig` moves: 0 = one element, 1 = one burst, 2 or 3 = the rest of the length. The completion action still decides events 0 and 1.
- R7: `doneOut` is a one-cycle pulse. `cfgOutGran` sets when it fires: 0 = after every element, 1 = after every burst end, 2 or 3 = after the last element.
- R8: `busy` rises in the cycle after a trigger is accepted. It stays high through memory stalls and falls after the final write of the released portion.
- R9: While `enabled` is low, triggers start no bus access and `busy` stays low. A channel that disabled itself is re-armed by `enableSet` or by an accepted load.
- R10: `enableClr` while busy ends the transfer at once: `busy` and `enabled` fall in the next cycle, event bit 7 is set, and the next start begins again from the base addresses.
- R11: If the current source or destination address is not a multiple of B when a trigger is accepted, event bit 4 (source) or bit 5 (destination) is set, no memory request is made and `busy` stays low.
- R12: An error response on a read sets event bit 2, and an error response on a write sets event bit 3. In both cases `busy` clears in the next cycle and the progress rewinds to the base addresses.
- R13: Event bits are sticky and are cleared by writing one to `evtClr`; a new event wins over a clear in the same cycle. `irq` is the OR of `events & evtMask`. A trigger that arrives before any configuration has been accepted sets event bit 6. Bit 8 is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgLoad | input | 1 | Load the cfg* fields |
| cfgSrcAddr | input | 32 | Source base address |
| cfgDstAddr | input | 32 | Destination base address |
| cfgSrcInc | input | 16 | Signed source step in elements |
| cfgDstInc | input | 16 | Signed destination step in elements |
| cfgWidthBits | input | 6 | Element width in bits (8, 16, 32) |
| cfgLength | input | 16 | Total elements |
| cfgBurst | input | 16 | Elements per burst, 0 = whole length |
| cfgAction | input | 2 | Completion action code |
| cfgInGran | input | 2 | Hardware trigger granularity |
| cfgOutGran | input | 2 | Output pulse granularity |
| cfgReject | output | 1 | Last load was refused |
| enableSet | input | 1 | Re-enable the channel |
| enableClr | input | 1 | Disable the channel, aborting if busy |
| enabled | output | 1 | Channel accepts triggers |
| swStart | input | 1 | Software start pulse |
| hwTrig | input | 1 | Hardware trigger pulse |
| busy | output | 1 | A released portion is in flight |
| evtMask | input | 9 | Interrupt enable per event bit |
| evtClr | input | 9 | Write-one-to-clear for event bits |
| events | output | 9 | Sticky event vector |
| irq | output | 1 | Masked interrupt |
| doneOut | output | 1 | Completion pulse |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address |
| memSize | output | 2 | Access size code |
| memWdata | output | 32 | Write data, right-justified |
| memRdata | input | 32 | Read data, right-justified |
| memAck | input | 1 | Request accepted this cycle |
| memErr | input | 1 | Error response with the acknowledge |

## Verification
Some properties are checked on every cycle:
- every memory request carries an address aligned to its size;
- an error response is always followed by an idle channel;
- a disabled channel is never busy;
- event bits never drop without a clear;
- completion pulses never merge.

Other behaviour is visible only in the bench's scenarios, which check both the memory contents and the cycle counts:
- the split of work between the completion actions and the trigger granularities;
- when events 0 and 1 are raised;
- the length of `busy` under stalls;
- rewinding after an abort;
- the refusal of malformed configurations.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int EV_W = 9;
  localparam int EV_TC      = 0;
  localparam int EV_DESC    = 1;
  localparam int EV_SRC_ERR = 2;
  localparam int EV_DST_ERR = 3;
  localparam int EV_SRC_MIS = 4;
  localparam int EV_DST_MIS = 5;
  localparam int EV_NOCFG   = 6;
  localparam int EV_DISABLE = 7;

  typedef enum logic [1:0] {
    GR_ELEM  = 2'd0,
    GR_BURST = 2'd1,
    GR_ALL   = 2'd2,
    GR_ALLX  = 2'd3
  } granE;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } stateE;

  typedef struct packed {
    logic loadCfg;
    logic rewind;
    logic step;
    logic capture;
    logic wrPhase;
  } dpStrobeT;

endpackage

// File: rtl/dma_seq_agen.sv
module dma_seq_agen #(
  parameter int ADDR_W = 32,
  parameter int INC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              rewind,
  input  logic              step,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [INC_W-1:0]  incIn,
  input  logic [1:0]        codeIn,
  output logic [ADDR_W-1:0] cur,
  output logic              misal
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] byteStep;
  logic [1:0]        code;
  logic [ADDR_W-1:0] incExt;

  assign incExt = {{(ADDR_W-INC_W){incIn[INC_W-1]}}, incIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base     <= '0;
      byteStep <= '0;
      code     <= 2'd0;
      cur      <= '0;
    end else if (load) begin
      base     <= baseIn;
      byteStep <= incExt << codeIn;
      code     <= codeIn;
      cur      <= baseIn;
    end else if (rewind) begin
      cur <= base;
    end else if (step) begin
      cur <= cur + byteStep;
    end
  end

  always_comb begin
    case (code)
      2'd1:    misal = cur[0];
      2'd2:    misal = |cur[1:0];
      default: misal = 1'b0;
    endcase
  end

endmodule

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int INC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          stb,
  input  logic [1:0]        cfgCode,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [INC_W-1:0]  cfgSrcInc,
  input  logic [INC_W-1:0]  cfgDstInc,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [1:0]        memSize,
  output logic              srcMis,
  output logic              dstMis
);

  localparam int NCH = 2;

  logic [NCH-1:0][ADDR_W-1:0] baseSel;
  logic [NCH-1:0][INC_W-1:0]  incSel;
  logic [NCH-1:0][ADDR_W-1:0] curArr;
  logic [NCH-1:0]             misArr;
  logic [1:0]                 wCode;
  logic [DATA_W-1:0]          rdReg;
  logic [DATA_W-1:0]          laneMask;

  assign baseSel = {cfgDstAddr, cfgSrcAddr};
  assign incSel  = {cfgDstInc, cfgSrcInc};

  for (genvar g = 0; g < NCH; g++) begin : gAgen
    dma_seq_agen #(.ADDR_W(ADDR_W), .INC_W(INC_W)) i_agen (
      .clk    (clk),
      .rstN   (rstN),
      .load   (stb.loadCfg),
      .rewind (stb.rewind),
      .step   (stb.step),
      .baseIn (baseSel[g]),
      .incIn  (incSel[g]),
      .codeIn (cfgCode),
      .cur    (curArr[g]),
      .misal  (misArr[g])
    );
  end

  always_comb begin
    case (wCode)
      2'd0:    laneMask = DATA_W'(8'hFF);
      2'd1:    laneMask = DATA_W'(16'hFFFF);
      default: laneMask = DATA_W'(32'hFFFF_FFFF);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wCode <= 2'd0;
      rdReg <= '0;
    end else begin
      if (stb.loadCfg) wCode <= cfgCode;
      if (stb.capture) rdReg <= memRdata & laneMask;
    end
  end

  assign memAddr  = stb.wrPhase ? curArr[1] : curArr[0];
  assign memWdata = rdReg;
  assign memSize  = wCode;
  assign srcMis   = misArr[0];
  assign dstMis   = misArr[1];

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgLoad,
  input  logic [5:0]      cfgWidthBits,
  input  logic [LEN_W-1:0] cfgLength,
  input  logic [LEN_W-1:0] cfgBurst,
  input  logic [1:0]      cfgAction,
  input  logic [1:0]      cfgInGran,
  input  logic [1:0]      cfgOutGran,
  input  logic            enableSet,
  input  logic            enableClr,
  input  logic            swStart,
  input  logic            hwTrig,
  input  logic [EV_W-1:0] evtMask,
  input  logic [EV_W-1:0] evtClr,
  input  logic            memAck,
  input  logic            memErr,
  input  logic            srcMis,
  input  logic            dstMis,
  output dpStrobeT        stb,
  output logic [1:0]      cfgCode,
  output logic            memReq,
  output logic            memWe,
  output logic            busy,
  output logic            enabled,
  output logic            cfgReject,
  output logic [EV_W-1:0] events,
  output logic            irq,
  output logic            doneOut
);

  stateE           state;
  granE            portionR, inGranR, outGranR, startPortion;
  logic            cfgValid, perBurstR, selfOffR;
  logic [LEN_W-1:0] lenR, beffR, totCnt, burstCnt;
  logic            widthOk, divOk, loadOk;
  logic            isIdle, abortDis, rdAck, wrAck, rdErr, wrErr, elemDone;
  logic            trigAny, trigOk, start, lastBurst, lastAll, tcHit, portionEnd, outHit;
  logic [EV_W-1:0] evSet;

  always_comb begin
    widthOk = 1'b1;
    case (cfgWidthBits)
      6'd8:    cfgCode = 2'd0;
      6'd16:   cfgCode = 2'd1;
      6'd32:   cfgCode = 2'd2;
      default: begin cfgCode = 2'd0; widthOk = 1'b0; end
    endcase
  end

  assign divOk  = (cfgBurst == '0) || ((cfgLength % cfgBurst) == '0);
  assign isIdle = (state == ST_IDLE);
  assign loadOk = cfgLoad && isIdle && widthOk && divOk && (cfgLength != '0);

  assign abortDis = enableClr && !isIdle;
  assign rdAck    = (state == ST_READ)  && memAck && !abortDis;
  assign wrAck    = (state == ST_WRITE) && memAck && !abortDis;
  assign rdErr    = rdAck && memErr;
  assign wrErr    = wrAck && memErr;
  assign elemDone = wrAck && !memErr;

  assign trigAny = swStart || hwTrig;
  assign trigOk  = isIdle && enabled && trigAny && !cfgLoad;
  assign start   = trigOk && !srcMis && !dstMis;

  assign lastBurst = ({1'b0, burstCnt} + 1'b1) == {1'b0, beffR};
  assign lastAll   = ({1'b0, totCnt} + 1'b1) == {1'b0, lenR};
  assign tcHit     = perBurstR ? lastBurst : lastAll;

  function automatic logic granHit(granE g, logic lb, logic la);
    case (g)
      GR_ELEM:  return 1'b1;
      GR_BURST: return lb;
      default:  return la;
    endcase
  endfunction

  assign portionEnd = granHit(portionR, lastBurst, lastAll);
  assign outHit     = granHit(outGranR, lastBurst, lastAll);

  always_comb begin
    if (swStart)                startPortion = perBurstR ? GR_BURST : GR_ALL;
    else if (inGranR == GR_ELEM)  startPortion = GR_ELEM;
    else if (inGranR == GR_BURST) startPortion = GR_BURST;
    else                          startPortion = GR_ALL;
  end

  always_comb begin
    evSet = '0;
    evSet[EV_NOCFG]   = trigAny && !cfgValid && !cfgLoad;
    evSet[EV_SRC_MIS] = trigOk && srcMis;
    evSet[EV_DST_MIS] = trigOk && dstMis;
    evSet[EV_SRC_ERR] = rdErr;
    evSet[EV_DST_ERR] = wrErr;
    evSet[EV_DISABLE] = abortDis;
    evSet[EV_TC]      = elemDone && tcHit;
    evSet[EV_DESC]    = elemDone && lastAll;
  end

  always_comb begin
    stb.loadCfg = loadOk;
    stb.rewind  = (elemDone && lastAll) || rdErr || wrErr || abortDis;
    stb.step    = elemDone && !lastAll;
    stb.capture = rdAck && !memErr;
    stb.wrPhase = (state == ST_WRITE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      portionR  <= GR_ALL;
      inGranR   <= GR_ELEM;
      outGranR  <= GR_ELEM;
      cfgValid  <= 1'b0;
      perBurstR <= 1'b0;
      selfOffR  <= 1'b0;
      lenR      <= '0;
      beffR     <= '0;
      totCnt    <= '0;
      burstCnt  <= '0;
      enabled   <= 1'b0;
      cfgReject <= 1'b0;
      events    <= '0;
      doneOut   <= 1'b0;
    end else begin
      events  <= (events & ~evtClr) | evSet;
      doneOut <= elemDone && outHit;
      if (cfgLoad) cfgReject <= !loadOk;

      if (loadOk) begin
        cfgValid  <= 1'b1;
        lenR      <= cfgLength;
        beffR     <= (cfgBurst == '0) ? cfgLength : cfgBurst;
        perBurstR <= (cfgBurst != '0) && !cfgAction[0];
        selfOffR  <= cfgAction[1];
        inGranR   <= granE'(cfgInGran);
        outGranR  <= granE'(cfgOutGran);
      end

      if (loadOk)                             enabled <= 1'b1;
      else if (enableClr)                     enabled <= 1'b0;
      else if (enableSet && cfgValid)         enabled <= 1'b1;
      else if (elemDone && lastAll && selfOffR) enabled <= 1'b0;

      if (loadOk || stb.rewind) begin
        totCnt   <= '0;
        burstCnt <= '0;
      end else if (elemDone) begin
        totCnt   <= totCnt + 1'b1;
        burstCnt <= lastBurst ? '0 : burstCnt + 1'b1;
      end

      if (abortDis || rdErr || wrErr) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (start) begin
            state    <= ST_READ;
            portionR <= startPortion;
          end
          ST_READ:  if (rdAck) state <= ST_WRITE;
          ST_WRITE: if (elemDone) state <= portionEnd ? ST_IDLE : ST_READ;
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  assign memReq = !isIdle;
  assign memWe  = (state == ST_WRITE);
  assign busy   = !isIdle;
  assign irq    = |(events & evtMask);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [INC_W-1:0]  cfgSrcInc,
  input  logic [INC_W-1:0]  cfgDstInc,
  input  logic [5:0]        cfgWidthBits,
  input  logic [LEN_W-1:0]  cfgLength,
  input  logic [LEN_W-1:0]  cfgBurst,
  input  logic [1:0]        cfgAction,
  input  logic [1:0]        cfgInGran,
  input  logic [1:0]        cfgOutGran,
  output logic              cfgReject,
  input  logic              enableSet,
  input  logic              enableClr,
  output logic              enabled,
  input  logic              swStart,
  input  logic              hwTrig,
  output logic              busy,
  input  logic [EV_W-1:0]   evtMask,
  input  logic [EV_W-1:0]   evtClr,
  output logic [EV_W-1:0]   events,
  output logic              irq,
  output logic              doneOut,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  input  logic              memErr
);

  dpStrobeT   stb;
  logic [1:0] cfgCode;
  logic       srcMis, dstMis;

  dma_seq_ctrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk, .rstN, .cfgLoad, .cfgWidthBits, .cfgLength, .cfgBurst, .cfgAction,
    .cfgInGran, .cfgOutGran, .enableSet, .enableClr, .swStart, .hwTrig,
    .evtMask, .evtClr, .memAck, .memErr, .srcMis, .dstMis, .stb, .cfgCode,
    .memReq, .memWe, .busy, .enabled, .cfgReject, .events, .irq, .doneOut
  );

  dma_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INC_W(INC_W)) i_dpath (
    .clk, .rstN, .stb, .cfgCode, .cfgSrcAddr, .cfgDstAddr, .cfgSrcInc,
    .cfgDstInc, .memRdata, .memAddr, .memWdata, .memSize, .srcMis, .dstMis
  );

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int EVW    = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memAck,
  input logic              memErr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [1:0]        memSize,
  input logic              busy,
  input logic              enabled,
  input logic              doneOut,
  input logic [EVW-1:0]    events,
  input logic [EVW-1:0]    evtClr
);

  logic [1:0] lowMask;
  assign lowMask = (memSize == 2'd2) ? 2'b11 : ((memSize == 2'd1) ? 2'b01 : 2'b00);

  AST_BUS_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ((memSize != 2'd3) && ((memAddr[1:0] & lowMask) == 2'b00))); // R11

  AST_ERR_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memErr) |=> !busy); // R12

  AST_OFF_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> !busy); // R9

  AST_EVENTS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|(events & ~evtClr)) |=> ((events & $past(events & ~evtClr)) == $past(events & ~evtClr))); // R13

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R7

endmodule

bind dma_chan_seq dma_seq_chk #(.ADDR_W(ADDR_W), .EVW(dma_seq_pkg::EV_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memReq  (memReq),
  .memAck  (memAck),
  .memErr  (memErr),
  .memAddr (memAddr),
  .memSize (memSize),
  .busy    (busy),
  .enabled (enabled),
  .doneOut (doneOut),
  .events  (events),
  .evtClr  (evtClr)
);

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgLoad = 0;
  logic [31:0] cfgSrcAddr = 0, cfgDstAddr = 0;
  logic [15:0] cfgSrcInc = 0, cfgDstInc = 0;
  logic [5:0]  cfgWidthBits = 6'd8;
  logic [15:0] cfgLength = 0, cfgBurst = 0;
  logic [1:0]  cfgAction = 0, cfgInGran = 0, cfgOutGran = 0;
  logic        cfgReject, enableSet = 0, enableClr = 0, enabled;
  logic        swStart = 0, hwTrig = 0, busy;
  logic [8:0]  evtMask = 0, evtClr = 0, events;
  logic        irq, doneOut, memReq, memWe;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [1:0]  memSize;
  logic        memAck, memErr;

  logic        stall = 0, errArm = 0, errOnWrite = 0, initReq = 0;
  logic [7:0]  errAddr = 0;
  logic [7:0]  mem [256];
  int          tests = 0, fails = 0, doneCnt = 0, reqCnt = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq i_dma_chan_seq (
    .clk, .rstN, .cfgLoad, .cfgSrcAddr, .cfgDstAddr, .cfgSrcInc, .cfgDstInc,
    .cfgWidthBits, .cfgLength, .cfgBurst, .cfgAction, .cfgInGran, .cfgOutGran,
    .cfgReject, .enableSet, .enableClr, .enabled, .swStart, .hwTrig, .busy,
    .evtMask, .evtClr, .events, .irq, .doneOut, .memReq, .memWe, .memAddr,
    .memSize, .memWdata, .memRdata, .memAck, .memErr
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a & 255) * 7 + 3);
  endfunction

  always_comb begin
    memAck   = memReq && !stall;
    memErr   = memAck && errArm && (memAddr[7:0] == errAddr) && (memWe == errOnWrite);
    memRdata = {mem[memAddr[7:0] + 8'd3], mem[memAddr[7:0] + 8'd2],
                mem[memAddr[7:0] + 8'd1], mem[memAddr[7:0]]};
  end

  always @(posedge clk) begin
    if (initReq) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else if (memReq && memWe && memAck && !memErr) begin
      for (int b = 0; b < (1 << memSize); b++) mem[8'(memAddr[7:0] + 8'(b))] <= memWdata[8*b +: 8];
    end
  end

  always @(negedge clk) begin
    if (doneOut) doneCnt++;
    if (memReq) reqCnt++;
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic initMem();
    @(negedge clk); initReq = 1;
    @(negedge clk); initReq = 0;
  endtask

  task automatic loadCfg(int wb, int src, int dst, int sInc, int dInc, int len, int bst,
                         int act, int ig, int og);
    @(negedge clk);
    cfgWidthBits = 6'(wb); cfgSrcAddr = 32'(src); cfgDstAddr = 32'(dst);
    cfgSrcInc = 16'(sInc); cfgDstInc = 16'(dInc); cfgLength = 16'(len);
    cfgBurst = 16'(bst); cfgAction = 2'(act); cfgInGran = 2'(ig); cfgOutGran = 2'(og);
    cfgLoad = 1;
    @(negedge clk); cfgLoad = 0;
  endtask

  task automatic clearEv();
    @(negedge clk); evtClr = '1;
    @(negedge clk); evtClr = '0;
  endtask

  task automatic runTrig(input bit hw, output int cyc);
    @(negedge clk); swStart = !hw; hwTrig = hw;
    @(negedge clk); swStart = 0; hwTrig = 0;
    cyc = 0;
    while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [5:0]  wb;
    logic [7:0]  src;
    logic [7:0]  dst;
    logic [15:0] sInc;
    logic [15:0] dInc;
    logic [15:0] len;
    logic [15:0] bst;
    logic [1:0]  act;
  } vecT;

  localparam vecT VECS [5] = '{
    '{6'd8,  8'h10, 8'h80, 16'd1,      16'd1,      16'd8, 16'd0, 2'd1},
    '{6'd16, 8'h20, 8'hA0, 16'd1,      16'd1,      16'd6, 16'd2, 2'd0},
    '{6'd32, 8'h40, 8'hDC, 16'd1,      16'hFFFF,   16'd4, 16'd2, 2'd1},
    '{6'd8,  8'h00, 8'h60, 16'd2,      16'd1,      16'd4, 16'd4, 2'd2},
    '{6'd16, 8'h30, 8'hE0, 16'd0,      16'd1,      16'd3, 16'd0, 2'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cyc, snap, nb, ntrig, ept, sI, dI;
    bit okMem;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R13 reset events", int'(events), 0);
    check("R8 reset busy", int'(busy), 0);
    check("R9 reset enabled", int'(enabled), 0);
    check("R7 reset doneOut", int'(doneOut), 0);
    check("R1 reset cfgReject", int'(cfgReject), 0);
    check("R13 reset irq", int'(irq), 0);

    // R13: trigger before any configuration
    runTrig(0, cyc);
    check("R13 nocfg busy", cyc, 0);
    check("R13 nocfg bit6", int'(events), 64);
    evtMask = 9'h040; #1;
    check("R13 irq masked on", int'(irq), 1);
    evtMask = 9'h001; #1;
    check("R13 irq masked off", int'(irq), 0);
    evtMask = 0;
    clearEv();
    check("R13 cleared", int'(events), 0);

    // R1: refused configurations
    loadCfg(12, 0, 0, 1, 1, 4, 0, 1, 0, 0);
    check("R1 bad width reject", int'(cfgReject), 1);
    check("R1 bad width not enabled", int'(enabled), 0);
    loadCfg(8, 0, 0, 1, 1, 6, 4, 1, 0, 0);
    check("R1 burst not dividing", int'(cfgReject), 1);
    loadCfg(8, 0, 0, 1, 1, 0, 0, 1, 0, 0);
    check("R1 zero length", int'(cfgReject), 1);
    loadCfg(8, 0, 0, 1, 1, 4, 2, 1, 0, 0);
    check("R1 good accepted", int'(cfgReject), 0);
    check("R1 good enables", int'(enabled), 1);

    // table of vectors: R2 R3 R4 R5
    foreach (VECS[v]) begin
      nb = int'(VECS[v].wb) / 8;
      sI = int'($signed(VECS[v].sInc));
      dI = int'($signed(VECS[v].dInc));
      if (VECS[v].bst != 0 && !VECS[v].act[0]) begin
        ntrig = int'(VECS[v].len / VECS[v].bst); ept = int'(VECS[v].bst);
      end else begin
        ntrig = 1; ept = int'(VECS[v].len);
      end
      initMem();
      loadCfg(int'(VECS[v].wb), int'(VECS[v].src), int'(VECS[v].dst), sI, dI,
              int'(VECS[v].len), int'(VECS[v].bst), int'(VECS[v].act), 2, 2);
      clearEv();
      for (int t = 0; t < ntrig; t++) begin
        runTrig(0, cyc);
        check("R3/R4 busy cycles per start", cyc, 2 * ept);
        check("R5 transfer complete", int'(events[0]), 1);
        check("R5 descriptor complete", int'(events[1]), (t == ntrig - 1) ? 1 : 0);
        clearEv();
      end
      okMem = 1;
      for (int k = 0; k < int'(VECS[v].len); k++)
        for (int b = 0; b < nb; b++)
          if (mem[(int'(VECS[v].dst) + k*dI*nb + b) & 255] != pat(int'(VECS[v].src) + k*sI*nb + b))
            okMem = 0;
      check("R2 destination contents", int'(okMem), 1);
      check("R4 enabled after end", int'(enabled), VECS[v].act[1] ? 0 : 1);
    end

    // R6 R7: element-granular hardware triggers under a full action
    initMem();
    loadCfg(8, 8'h10, 8'h80, 1, 1, 4, 2, 1, 0, 0);
    clearEv();
    snap = doneCnt;
    runTrig(1, cyc);
    check("R6 hw element cycles", cyc, 2);
    check("R6 hw element moved", int'(mem[8'h80]), int'(pat(8'h10)));
    check("R6 hw element only one", int'(mem[8'h81]), int'(pat(8'h81)));
    check("R7 pulse per element", doneCnt - snap, 1);
    runTrig(1, cyc);
    check("R6 full action no tc at burst edge", int'(events), 0);
    runTrig(0, cyc);
    check("R6 sw moves remainder", cyc, 4);
    check("R5 events at end", int'(events), 3);
    check("R7 pulse count element", doneCnt - snap, 4);

    loadCfg(8, 8'h10, 8'h80, 1, 1, 4, 2, 0, 2, 1);
    clearEv();
    snap = doneCnt;
    runTrig(1, cyc);
    check("R6 hw all cycles", cyc, 8);
    check("R6 hw all events", int'(events), 3);
    check("R7 pulse per burst", doneCnt - snap, 2);

    // R9: self-disable and re-enable
    loadCfg(8, 8'h10, 8'h80, 1, 1, 2, 1, 2, 0, 0);
    clearEv();
    runTrig(0, cyc);
    check("R9 first burst", cyc, 2);
    check("R9 still enabled", int'(enabled), 1);
    runTrig(0, cyc);
    check("R9 disabled at end", int'(enabled), 0);
    snap = reqCnt;
    runTrig(0, cyc);
    check("R9 trigger ignored busy", cyc, 0);
    check("R9 trigger ignored no access", reqCnt - snap, 0);
    @(negedge clk); enableSet = 1;
    @(negedge clk); enableSet = 0;
    check("R9 re-enabled", int'(enabled), 1);
    runTrig(0, cyc);
    check("R9 runs after re-enable", cyc, 2);

    // R8: stall keeps busy high
    loadCfg(8, 8'h10, 8'h80, 1, 1, 1, 0, 1, 0, 0);
    @(negedge clk); stall = 1; swStart = 1;
    @(negedge clk); swStart = 0;
    repeat (4) @(negedge clk);
    check("R8 busy during stall", int'(busy), 1);
    stall = 0;
    cyc = 0;
    while (busy && cyc < 100) begin cyc++; @(negedge clk); end
    check("R8 busy after stall release", cyc, 2);

    // R10: disable while active
    loadCfg(8, 8'h10, 8'h80, 1, 1, 8, 0, 1, 0, 0);
    clearEv();
    @(negedge clk); swStart = 1;
    @(negedge clk); swStart = 0;
    @(negedge clk); @(negedge clk);
    enableClr = 1;
    @(negedge clk); enableClr = 0;
    check("R10 busy cleared", int'(busy), 0);
    check("R10 enabled cleared", int'(enabled), 0);
    check("R10 event bit7", int'(events), 128);

    // R11: misalignment
    loadCfg(16, 8'h21, 8'h80, 1, 1, 2, 0, 1, 0, 0);
    clearEv();
    snap = reqCnt;
    runTrig(0, cyc);
    check("R11 src misaligned busy", cyc, 0);
    check("R11 src misaligned event", int'(events), 16);
    check("R11 no bus access", reqCnt - snap, 0);
    loadCfg(32, 8'h40, 8'h42, 1, 1, 2, 0, 1, 0, 0);
    runTrig(0, cyc);
    check("R11 dst misaligned event", int'(events), 48);
    @(negedge clk); evtClr = 9'h010;
    @(negedge clk); evtClr = 0;
    check("R13 w1c one bit", int'(events), 32);
    evtMask = 9'h020; #1;
    check("R13 irq from bit5", int'(irq), 1);
    evtMask = 0;
    clearEv();

    // R12: bus errors
    loadCfg(8, 8'h10, 8'h80, 1, 1, 4, 0, 1, 0, 0);
    errArm = 1; errOnWrite = 0; errAddr = 8'h11;
    runTrig(0, cyc);
    check("R12 read error busy", cyc, 3);
    check("R12 read error event", int'(events), 4);
    clearEv();
    errOnWrite = 1; errAddr = 8'h80;
    runTrig(0, cyc);
    check("R12 write error busy", cyc, 2);
    check("R12 write error event", int'(events), 8);
    clearEv();
    errArm = 0;
    runTrig(0, cyc);
    check("R12 rewound full rerun", cyc, 8);
    check("R12 rerun events", int'(events), 3);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule